// File: doc/BRIEF.md
# Multiturn Revolution Counter with Overlap Synchronization

This block keeps a count of completed shaft revolutions next to a singleturn angle, so that the two together give an absolute multiturn position. The angle comes in every clock cycle. A revolution is counted whenever the two most significant angle bits pass through zero, in either direction. The count is 24 bits wide by default and wraps around at its limits.

When an external multiturn source is configured, the counter stays at zero and unlocked until a multiturn word has been read without a read error. That word carries a few low overlap bits that repeat the top bits of the angle. The block compares those overlap bits with the live angle to work out the signed sector offset between them. It then removes that offset from the word and drops the overlap bits, which moves the loaded count up or down by one revolution when the reading and the angle sit on opposite sides of the zero crossing. If the offset is exactly half a revolution, the result cannot be resolved: the block raises a sync error, loads nothing and waits for the next word. After it has locked, the block counts on its own and ignores any further external words. When no external source is configured (mode code 0), the block locks at once and counts from zero.

Top module: `mt_period_sync`

## Requirements
- R1: While `rst` is high, at the next clock edge `mt_count`, the angle part of `pos_out`, `locked`, `sync_err` and `cfg_bad` all become 0.
- R2: With `cfg_mode` = 0, `locked` rises at the first clock edge after reset and the count starts from 0 without any external word.
- R3: While locked, at each edge where `st_angle[15:14]` moves from 2'b11 (held in the register) to 2'b00 (input), the count goes up by 1. Where it moves from 2'b00 to 2'b11, the count goes down by 1. Every other transition leaves the count unchanged.
- R4: The count wraps modulo 2^24: incrementing 0xFFFFFF gives 0, and decrementing 0 gives 0xFFFFFF.
- R5: With `cfg_mode` ≠ 0, the block stays unlocked with the count at 0 until it accepts an external word. A word presented with `ext_err` = 1 is ignored.
- R6: Overlap length L = `cfg_sync_len` + 1 (1 to 4). Let e be `ext_word[L-1:0]` and a be `st_angle[15:16-L]`, and let d = (e − a) mod 2^L, read as negative (d − 2^L) when d > 2^(L−1). The loaded count is ((`ext_word` − d) mod 2^28) >> L, taken to 24 bits. It appears on `mt_count` with `locked` = 1 after the edge where the word is accepted.
- R7: If d = 2^(L−1), the word is rejected: `sync_err` becomes 1, nothing is loaded and the block stays unlocked. A later accepted word clears `sync_err`.
- R8: Once `locked` is 1, it stays 1 until reset, and `ext_valid` has no effect on the count.
- R9: `cfg_bad` is registered and is 1 when `cfg_periods` ≥ 7 and `cfg_mode` is neither 0x0 nor 0xD.
- R10: `pos_out` = {count, angle}, where the angle is `st_angle` as sampled at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_angle | input | 16 | Singleturn angle, sampled every cycle |
| ext_valid | input | 1 | External multiturn word is present this cycle |
| ext_word | input | 28 | External word: overlap bits in the low L bits, count above them |
| ext_err | input | 1 | The serial read of this word failed |
| cfg_mode | input | 4 | Multiturn source mode; 0 means internal counting only |
| cfg_sync_len | input | 2 | Overlap length code, L = code + 1 |
| cfg_periods | input | 4 | Period-count setting, used only for the validity check |
| mt_count | output | 24 | Revolution count |
| pos_out | output | 40 | Count concatenated with the registered angle |
| locked | output | 1 | The count is valid and running |
| sync_err | output | 1 | The last accepted word was out of phase tolerance |
| cfg_bad | output | 1 | Mode and period settings form a disallowed combination |

## Verification
Some properties hold on every cycle, and the assertions check those. Once locked, the count never moves by more than one step per cycle. `locked` never falls without a reset. The count stays at zero while the block is unlocked. A sync error is never present at the same time as a lock. Mode 0 always locks on the next cycle, and it never reports a bad configuration. The exact arithmetic, by contrast, can only be shown by the bench's scenarios with chosen angles and words. Those cover the ±1 correction at each overlap length, the rejection of a word exactly half a revolution out, the wrap at both ends of the count, and the ignoring of words that have a read error or that arrive after lock.

// File: rtl/mt_sync_pkg.sv
package mt_sync_pkg;
  // widest overlap field supported by the sync-length code
  localparam int unsigned SYNC_MAX = 4;
  // angle bits used for revolution-crossing detection
  localparam int unsigned WRAP_BITS = 2;
endpackage

// File: rtl/mt_wrap_detect.sv
module mt_wrap_detect
  import mt_sync_pkg::*;
#(
  parameter int unsigned ST_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] angle,
  output logic [ST_W-1:0] angle_q,
  output logic            wrap_up,
  output logic            wrap_dn
);
  localparam logic [WRAP_BITS-1:0] TOP_HI = '1;
  localparam logic [WRAP_BITS-1:0] TOP_LO = '0;

  logic [WRAP_BITS-1:0] prev_top, cur_top;

  always_ff @(posedge clk) begin
    if (rst) angle_q <= '0;
    else     angle_q <= angle;
  end

  assign prev_top = angle_q[ST_W-1 -: WRAP_BITS];
  assign cur_top  = angle[ST_W-1 -: WRAP_BITS];
  assign wrap_up  = (prev_top == TOP_HI) && (cur_top == TOP_LO);
  assign wrap_dn  = (prev_top == TOP_LO) && (cur_top == TOP_HI);
endmodule

// File: rtl/mt_sync_align.sv
module mt_sync_align
  import mt_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned ST_W  = 16,
  parameter int unsigned EXT_W = CNT_W + SYNC_MAX
) (
  input  logic [EXT_W-1:0] ext_word,
  input  logic [ST_W-1:0]  angle,
  input  logic [1:0]       sync_code,
  output logic [CNT_W-1:0] aligned,
  output logic             phase_bad
);
  logic [2:0]          len;
  logic [4:0]          span;
  logic [SYNC_MAX-1:0] mask, half, st_top, a_sec, e_sec, diff;
  logic [EXT_W-1:0]    adj, shifted;

  assign st_top = angle[ST_W-1 -: SYNC_MAX];

  always_comb begin
    len       = {1'b0, sync_code} + 3'd1;
    span      = 5'd1 << len;
    mask      = 4'(span - 5'd1);
    half      = 4'(span >> 1);
    a_sec     = st_top >> (3'd4 - len);
    e_sec     = ext_word[SYNC_MAX-1:0] & mask;
    diff      = (e_sec - a_sec) & mask;
    phase_bad = (diff == half);
    // offset above half a revolution is a negative offset
    if (diff > half) adj = ext_word + EXT_W'(span) - EXT_W'(diff);
    else             adj = ext_word - EXT_W'(diff);
    shifted   = adj >> len;
    aligned   = shifted[CNT_W-1:0];
  end
endmodule

// File: rtl/mt_rev_counter.sv
module mt_rev_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             up,
  input  logic             dn,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)            count <= '0;
    else if (load)      count <= load_val;
    else if (run && up) count <= count + 1'b1;
    else if (run && dn) count <= count - 1'b1;
  end
endmodule

// File: rtl/mt_period_sync.sv
module mt_period_sync
  import mt_sync_pkg::*;
#(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned ST_W       = 16,
  parameter int unsigned MODE_W     = 4,
  parameter int unsigned PER_W      = 4,
  parameter int unsigned PER_LIMIT  = 7,
  parameter int unsigned SAFE_MODE  = 13,
  parameter int unsigned EXT_W      = CNT_W + SYNC_MAX
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ST_W-1:0]       st_angle,
  input  logic                  ext_valid,
  input  logic [EXT_W-1:0]      ext_word,
  input  logic                  ext_err,
  input  logic [MODE_W-1:0]     cfg_mode,
  input  logic [1:0]            cfg_sync_len,
  input  logic [PER_W-1:0]      cfg_periods,
  output logic [CNT_W-1:0]      mt_count,
  output logic [CNT_W+ST_W-1:0] pos_out,
  output logic                  locked,
  output logic                  sync_err,
  output logic                  cfg_bad
);
  localparam logic [MODE_W-1:0] MODE_SAFE = MODE_W'(SAFE_MODE);
  localparam logic [PER_W-1:0]  PER_MAX   = PER_W'(PER_LIMIT);

  logic [ST_W-1:0]  angle_q;
  logic             wrap_up, wrap_dn;
  logic [CNT_W-1:0] aligned;
  logic             phase_bad;
  logic             internal_only, ext_take, do_load;

  mt_wrap_detect #(.ST_W(ST_W)) wrap_i (
    .clk(clk), .rst(rst), .angle(st_angle),
    .angle_q(angle_q), .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  mt_sync_align #(.CNT_W(CNT_W), .ST_W(ST_W), .EXT_W(EXT_W)) align_i (
    .ext_word(ext_word), .angle(st_angle), .sync_code(cfg_sync_len),
    .aligned(aligned), .phase_bad(phase_bad)
  );

  assign internal_only = (cfg_mode == '0);
  assign ext_take      = !locked && !internal_only && ext_valid && !ext_err;
  assign do_load       = ext_take && !phase_bad;

  mt_rev_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .load(do_load), .load_val(aligned),
    .run(locked), .up(wrap_up), .dn(wrap_dn), .count(mt_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      sync_err <= 1'b0;
      cfg_bad  <= 1'b0;
    end else begin
      if (!locked && (internal_only || do_load)) locked <= 1'b1;
      if (ext_take) sync_err <= phase_bad;
      cfg_bad <= (cfg_periods >= PER_MAX) && !internal_only && (cfg_mode != MODE_SAFE);
    end
  end

  assign pos_out = {mt_count, angle_q};
endmodule

// File: rtl/mt_period_sync_chk.sv
module mt_period_sync_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned MODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] cfg_mode,
  input logic [CNT_W-1:0]  mt_count,
  input logic              locked,
  input logic              sync_err,
  input logic              cfg_bad
);
  AST_MODE0_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (!locked && cfg_mode == '0) |=> locked); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    locked |=> (mt_count == $past(mt_count) || mt_count == $past(mt_count) + 1'b1
                || mt_count == $past(mt_count) - 1'b1)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (mt_count == '0)); // R5

  AST_ERR_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> !locked); // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R8

  AST_MODE0_VALID: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == '0) |=> !cfg_bad); // R9
endmodule

bind mt_period_sync mt_period_sync_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .mt_count(mt_count),
  .locked(locked), .sync_err(sync_err), .cfg_bad(cfg_bad)
);

// File: tb/mt_period_sync_tb_top.sv
module mt_period_sync_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] st_angle = '0;
  logic        ext_valid = 1'b0;
  logic [27:0] ext_word = '0;
  logic        ext_err = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic [1:0]  cfg_sync_len = '0;
  logic [3:0]  cfg_periods = '0;
  logic [23:0] mt_count;
  logic [39:0] pos_out;
  logic        locked, sync_err, cfg_bad;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [39:0] pos;
    logic        lck;
    logic        err;
    logic        cbad;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  mt_period_sync dut_i (
    .clk(clk), .rst(rst), .st_angle(st_angle), .ext_valid(ext_valid),
    .ext_word(ext_word), .ext_err(ext_err), .cfg_mode(cfg_mode),
    .cfg_sync_len(cfg_sync_len), .cfg_periods(cfg_periods),
    .mt_count(mt_count), .pos_out(pos_out), .locked(locked),
    .sync_err(sync_err), .cfg_bad(cfg_bad)
  );

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (pos_out !== e.pos || mt_count !== e.pos[39:16] || locked !== e.lck
          || sync_err !== e.err || cfg_bad !== e.cbad) begin
        bad++;
        $display("FAIL %s: pos=%h lck=%b err=%b bad=%b expected pos=%h lck=%b err=%b bad=%b",
                 e.tag, pos_out, locked, sync_err, cfg_bad, e.pos, e.lck, e.err, e.cbad);
      end
    end
  end

  task automatic push(input string tag, input logic [23:0] c, input logic [15:0] a,
                      input logic l, input logic e, input logic b);
    exp_t it;
    it.tag = tag; it.pos = {c, a}; it.lck = l; it.err = e; it.cbad = b;
    sb.push_back(it);
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [15:0] ang, input logic ev, input logic [27:0] w,
                      input logic ee, input string tag, input logic [23:0] c,
                      input logic l, input logic e, input logic b);
    st_angle = ang; ext_valid = ev; ext_word = w; ext_err = ee;
    @(posedge clk); #1;
    push(tag, c, ang, l, e, b);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] m, input logic [1:0] s, input logic [3:0] p);
    cfg_mode = m; cfg_sync_len = s; cfg_periods = p;
    rst = 1'b1; ext_valid = 1'b0; ext_err = 1'b0; st_angle = 16'h5555;
    @(posedge clk); #1;
    push("R1 reset state", 24'd0, 16'h0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // internal counting only; period setting high but mode 0 is allowed (R9)
    do_reset(4'h0, 2'd0, 4'd7);
    step(16'h8000, 0, 0, 0, "R2 lock in mode 0",      24'd0,        1, 0, 0);
    step(16'hF000, 0, 0, 0, "R3 no crossing",         24'd0,        1, 0, 0);
    step(16'h1000, 0, 0, 0, "R3 forward crossing",    24'd1,        1, 0, 0);
    step(16'hF000, 0, 0, 0, "R3 reverse crossing",    24'd0,        1, 0, 0);
    step(16'h8000, 0, 0, 0, "R3 11 to 10 no change",  24'd0,        1, 0, 0);
    step(16'h2000, 0, 0, 0, "R3 10 to 00 no change",  24'd0,        1, 0, 0);
    step(16'hE000, 0, 0, 0, "R4 wrap below zero",     24'hFFFFFF,   1, 0, 0);
    step(16'h0100, 0, 0, 0, "R4 wrap above max",      24'd0,        1, 0, 0);

    // external source, L=2
    do_reset(4'hD, 2'd1, 4'd7);
    step(16'h1000, 0, 0,         0, "R5 wait for word",          24'd0,   0, 0, 0);
    step(16'h1000, 1, 28'd403,   1, "R5 read-error word ignored",24'd0,   0, 0, 0);
    step(16'h1000, 1, 28'd22,    0, "R7 half-turn reject",       24'd0,   0, 1, 0);
    step(16'h1000, 1, 28'd403,   0, "R6 load with +1 correction",24'd101, 1, 0, 0);
    step(16'h1000, 1, 28'd28,    0, "R8 word after lock ignored",24'd101, 1, 0, 0);
    step(16'hF000, 0, 0,         0, "R3 reverse after load",     24'd100, 1, 0, 0);
    cfg_mode = 4'h3;
    step(16'hF000, 0, 0,         0, "R9 disallowed mode flagged",24'd100, 1, 0, 1);

    // L=2, external word one sector ahead of the angle
    do_reset(4'hD, 2'd1, 4'd0);
    step(16'hF000, 1, 28'd400,   0, "R6 load with -1 correction",24'd99,  1, 0, 0);

    // L=1
    do_reset(4'h2, 2'd0, 4'd0);
    step(16'h9000, 1, 28'd40,    0, "R7 L1 reject",              24'd0,   0, 1, 0);
    step(16'h9000, 1, 28'd41,    0, "R7 L1 retry clears error",  24'd20,  1, 0, 0);

    // L=4, largest tolerated positive offset
    do_reset(4'hE, 2'd3, 4'd0);
    step(16'h9000, 1, 28'd800,   0, "R6 L4 offset of 7 sectors", 24'd49,  1, 0, 0);

    // L=4, correction wraps the count
    do_reset(4'hE, 2'd3, 4'd0);
    step(16'h0800, 1, 28'hFFFFFFF, 0, "R4 load correction wraps",24'd0,   1, 0, 0);

    // L=3
    do_reset(4'hC, 2'd2, 4'd0);
    step(16'h0000, 1, 28'd84,    0, "R7 L3 reject",              24'd0,   0, 1, 0);
    step(16'h0000, 1, 28'd83,    0, "R6 L3 offset of 3 sectors", 24'd10,  1, 0, 0);
    step(16'h4000, 0, 0,         0, "R10 angle tracks input",    24'd10,  1, 0, 0);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule